// File: doc/BRIEF.md
# SPI Status Autopoll Engine

This block lets a fast SPI master wait on a device status bit without processor involvement. Once software starts it, the engine runs a loop of short transactions: it selects the device, sends a one-byte command, reads one byte back, deselects, and tests a chosen bit of that byte against an expected value. The loop ends when the bit matches, when the allowed number of tries has been used up, or when software aborts it.

The outcome is recorded in a small interrupt status register that also records the transfer-finished event of the bulk data path. Each status bit has a mask bit. A single interrupt line pulses whenever an unmasked status bit goes from 0 to 1. Status bits are cleared by writing 1 to them. The bulk data path is not part of this block. The engine reaches the bus through a simple request/acknowledge byte exchange port and a chip-select output.

Top module: `spi_autopoll`

## Requirements
- R1: Each try drives chip select low (cs_n = 0) for exactly two byte exchanges. The first exchange sends the command byte from bits 7:0 of the poll word, and the second sends 8'h00. A byte exchange is requested (xb_req = 1) only while chip select is low.
- R2: A try matches when bit N of the byte received in the second exchange equals bit 30 of the poll word, where N is bits 26:24 of the poll word. The byte received in the first exchange is never tested.
- R3: The try limit is 31 shifted left by (clk_sel + poll word bits 19:16). If no try matches, the engine stops after exactly that many tries. A match on the final allowed try counts as success.
- R4: Writing the poll word with bit 31 = 1 while idle starts polling. Bit 31 of poll_rdata reads 1 from the next cycle until the engine stops. While polling, the other fields read back as written, and undefined bits read 0.
- R5: Between two tries, chip select stays high for exactly GAP_CYCLES + 1 cycles.
- R6: Status bit 0 records xfer_done, bit 1 records a match (success), and bit 2 records that the try limit was reached (timeout). The success or timeout bit is set in the same cycle that bit 31 of poll_rdata returns to 0.
- R7: A status write clears each bit that is written as 1 and leaves each bit written as 0 unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R8: A mask bit of 1 stops the matching status bit from raising irq. The status bit is still recorded.
- R9: irq is high for one cycle, in the first cycle that an unmasked status bit reads 1 after having read 0. Several bits rising in the same cycle give a single pulse.
- R10: Writing the poll word with bit 31 = 0 while polling aborts the engine. From the next cycle busy reads 0, chip select is high, no further try starts, and no status bit is set.
- R11: After reset: status = 0, mask = 0, the poll word reads 0, cs_n = 1, xb_req = 0, irq = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Serial clock select from the master control; one term of the try-limit shift |
| poll_wr | input | 1 | Write strobe for the poll word |
| poll_wdata | input | 32 | Poll word: command 7:0, timeout 19:16, bit select 26:24, polarity 30, run 31 |
| poll_rdata | output | 32 | Poll word readback; bit 31 is busy |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 3 | Mask bits, 1 = event disabled |
| stat_wr | input | 1 | Write strobe for status clear |
| stat_wdata | input | 3 | Write-one-to-clear bits |
| stat_rdata | output | 3 | Status: bit 0 transfer finished, bit 1 success, bit 2 timeout |
| xfer_done | input | 1 | One-cycle transfer-finished event from the bulk path |
| irq | output | 1 | Interrupt pulse |
| cs_n | output | 1 | Device chip select, active low |
| xb_req | output | 1 | Byte exchange request |
| xb_tx | output | 8 | Byte to send |
| xb_ack | input | 1 | Byte exchange complete |
| xb_rx | input | 8 | Byte received, valid with xb_ack |

## Verification
The critical cycle is the one in which the engine finishes on a match. In that same cycle, the bulk path can report transfer finished and software can write a status clear. To provoke this, the bench's device model watches chip select rise on the matching try. Half a cycle later it raises xfer_done and a clear write of all three bits together, so all three land on the completion edge. The result is judged correct if both the success and transfer bits read 1 afterwards, because set beats clear, and exactly one irq pulse is counted for the two simultaneous rises.

// File: rtl/spi_apoll_pkg.sv
package spi_apoll_pkg;

    // Register and field geometry
    localparam int REG_W    = 32;
    localparam int CMD_LSB  = 0;
    localparam int CMD_W    = 8;
    localparam int TMO_LSB  = 16;
    localparam int TMO_W    = 4;
    localparam int BSEL_LSB = 24;
    localparam int BSEL_W   = 3;
    localparam int POL_BIT  = 30;
    localparam int RUN_BIT  = 31;
    localparam int CLKSEL_W = 3;

    // Interrupt event positions
    localparam int EV_XFER  = 0;
    localparam int EV_OK    = 1;
    localparam int EV_TMO   = 2;
    localparam int EV_N     = 3;

    typedef struct packed {
        logic              pol;
        logic [BSEL_W-1:0] bsel;
        logic [TMO_W-1:0]  tmo;
        logic [CMD_W-1:0]  cmd;
    } poll_cfg_t;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_CMD,
        PS_RESP,
        PS_REL,
        PS_GAP
    } poll_st_t;

    function automatic poll_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        poll_cfg_t c;
        c.cmd  = w[CMD_LSB +: CMD_W];
        c.tmo  = w[TMO_LSB +: TMO_W];
        c.bsel = w[BSEL_LSB +: BSEL_W];
        c.pol  = w[POL_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] word_from_cfg(input poll_cfg_t c, input logic run);
        logic [REG_W-1:0] w;
        w = '0;
        w[CMD_LSB +: CMD_W]   = c.cmd;
        w[TMO_LSB +: TMO_W]   = c.tmo;
        w[BSEL_LSB +: BSEL_W] = c.bsel;
        w[POL_BIT]            = c.pol;
        w[RUN_BIT]            = run;
        return w;
    endfunction

endpackage

// File: rtl/apoll_ctl.sv
module apoll_ctl
    import spi_apoll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             poll_wr,
    input  logic [REG_W-1:0] poll_wdata,
    input  logic             fin,
    output logic             start,
    output logic             abort,
    output logic             busy,
    output poll_cfg_t        cfg_q,
    output logic [REG_W-1:0] rdata
);

    // Start only from idle; a run-bit-low write while busy cancels.
    assign start = poll_wr &&  poll_wdata[RUN_BIT] && !busy;
    assign abort = poll_wr && !poll_wdata[RUN_BIT] &&  busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cfg_q <= '0;
        end else begin
            if (poll_wr && !busy) begin
                cfg_q <= cfg_from_word(poll_wdata);
            end
            if (start) begin
                busy <= 1'b1;
            end else if (abort || fin) begin
                busy <= 1'b0;
            end
        end
    end

    assign rdata = word_from_cfg(cfg_q, busy);

endmodule

// File: rtl/apoll_seq.sv
module apoll_seq
    import spi_apoll_pkg::*;
#(
    parameter int BASE_TRIES = 31,
    parameter int GAP_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  poll_cfg_t           cfg,
    input  logic [CLKSEL_W-1:0] clk_sel,
    input  logic                xb_ack,
    input  logic [CMD_W-1:0]    xb_rx,
    output logic                cs_n,
    output logic                xb_req,
    output logic [CMD_W-1:0]    xb_tx,
    output logic                fin_ok,
    output logic                fin_tmo
);

    localparam int MAX_SH  = (2**CLKSEL_W - 1) + (2**TMO_W - 1);
    localparam int SH_W    = $clog2(MAX_SH + 1);
    localparam int LIMIT_W = $clog2(BASE_TRIES + 1) + MAX_SH;
    localparam int GAP_W   = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

    poll_st_t           st;
    logic [LIMIT_W-1:0] tries;
    logic [LIMIT_W-1:0] limit;
    logic [SH_W-1:0]    shamt;
    logic [GAP_W-1:0]   gap;
    logic               hit;
    logic               in_xfer;
    logic               at_limit;

    assign shamt    = SH_W'(clk_sel) + SH_W'(cfg.tmo);
    assign limit    = LIMIT_W'(BASE_TRIES) << shamt;
    assign at_limit = (tries == limit);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st    <= PS_IDLE;
            tries <= '0;
            gap   <= '0;
            hit   <= 1'b0;
        end else begin
            case (st)
                PS_IDLE: begin
                    if (start) begin
                        st    <= PS_CMD;
                        tries <= '0;
                    end
                end
                PS_CMD: begin
                    if (xb_ack) st <= PS_RESP;
                end
                PS_RESP: begin
                    if (xb_ack) begin
                        hit   <= (xb_rx[cfg.bsel] == cfg.pol);
                        tries <= tries + LIMIT_W'(1);
                        st    <= PS_REL;
                    end
                end
                PS_REL: begin
                    if (hit || at_limit) begin
                        st <= PS_IDLE;
                    end else begin
                        st  <= PS_GAP;
                        gap <= '0;
                    end
                end
                PS_GAP: begin
                    if (gap == GAP_LAST) st <= PS_CMD;
                    else                 gap <= gap + GAP_W'(1);
                end
                default: st <= PS_IDLE;
            endcase
        end
    end

    assign in_xfer = (st == PS_CMD) || (st == PS_RESP);
    assign cs_n    = !in_xfer;
    assign xb_req  = in_xfer;
    assign xb_tx   = (st == PS_CMD) ? cfg.cmd : '0;
    assign fin_ok  = (st == PS_REL) &&  hit && !abort;
    assign fin_tmo = (st == PS_REL) && !hit && at_limit && !abort;

endmodule

// File: rtl/apoll_irq.sv
module apoll_irq
    import spi_apoll_pkg::*;
#(
    parameter int N = EV_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_bits,
    output logic [N-1:0] stat_q,
    output logic         irq
);

    logic [N-1:0] mask_q;
    logic [N-1:0] stat_d;
    logic [N-1:0] rise;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Set has priority over a same-cycle clear.
        assign stat_d[i] = ev[i] | (stat_q[i] & !(clr_wr && clr_bits[i]));
        assign rise[i]   = stat_d[i] & !stat_q[i] & !mask_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= 1'b0;
                mask_q[i] <= 1'b0;
            end else begin
                stat_q[i] <= stat_d[i];
                if (mask_wr) mask_q[i] <= mask_bits[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |rise;
    end

endmodule

// File: rtl/spi_autopoll.sv
module spi_autopoll
    import spi_apoll_pkg::*;
#(
    parameter int BASE_TRIES = 31,
    parameter int GAP_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CLKSEL_W-1:0] clk_sel,
    input  logic                poll_wr,
    input  logic [REG_W-1:0]    poll_wdata,
    output logic [REG_W-1:0]    poll_rdata,
    input  logic                mask_wr,
    input  logic [EV_N-1:0]     mask_wdata,
    input  logic                stat_wr,
    input  logic [EV_N-1:0]     stat_wdata,
    output logic [EV_N-1:0]     stat_rdata,
    input  logic                xfer_done,
    output logic                irq,
    output logic                cs_n,
    output logic                xb_req,
    output logic [CMD_W-1:0]    xb_tx,
    input  logic                xb_ack,
    input  logic [CMD_W-1:0]    xb_rx
);

    logic            start;
    logic            abort;
    logic            busy;
    logic            fin_ok;
    logic            fin_tmo;
    poll_cfg_t       cfg_q;
    logic [EV_N-1:0] ev;

    apoll_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .poll_wr    (poll_wr),
        .poll_wdata (poll_wdata),
        .fin        (fin_ok | fin_tmo),
        .start      (start),
        .abort      (abort),
        .busy       (busy),
        .cfg_q      (cfg_q),
        .rdata      (poll_rdata)
    );

    apoll_seq #(
        .BASE_TRIES (BASE_TRIES),
        .GAP_CYCLES (GAP_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .abort   (abort),
        .cfg     (cfg_q),
        .clk_sel (clk_sel),
        .xb_ack  (xb_ack),
        .xb_rx   (xb_rx),
        .cs_n    (cs_n),
        .xb_req  (xb_req),
        .xb_tx   (xb_tx),
        .fin_ok  (fin_ok),
        .fin_tmo (fin_tmo)
    );

    always_comb begin
        ev          = '0;
        ev[EV_XFER] = xfer_done;
        ev[EV_OK]   = fin_ok;
        ev[EV_TMO]  = fin_tmo;
    end

    apoll_irq #(.N(EV_N)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .clr_wr    (stat_wr),
        .clr_bits  (stat_wdata),
        .mask_wr   (mask_wr),
        .mask_bits (mask_wdata),
        .stat_q    (stat_rdata),
        .irq       (irq)
    );

endmodule

// File: rtl/spi_autopoll_chk.sv
module spi_autopoll_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       cs_n,
    input logic       xb_req,
    input logic       poll_wr,
    input logic       poll_run,
    input logic       stat_wr,
    input logic [2:0] stat_wdata,
    input logic [2:0] stat_q,
    input logic       irq
);

    logic [2:0] clr_req;
    assign clr_req = stat_wr ? stat_wdata : 3'b000;

    // R1
    req_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
        xb_req |-> !cs_n);

    // R4
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    // R10
    abort_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && poll_wr && !poll_run) |=> (!busy && cs_n));

    // R6
    ok_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[1]) |-> $fell(busy));

    // R6
    tmo_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[2]) |-> $fell(busy));

    // R7
    sticky_stat_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(stat_q) & ~$past(clr_req)) & ~stat_q) == 3'b000));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((stat_q & ~$past(stat_q)) != 3'b000));

endmodule

bind spi_autopoll spi_autopoll_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (poll_rdata[31]),
    .cs_n       (cs_n),
    .xb_req     (xb_req),
    .poll_wr    (poll_wr),
    .poll_run   (poll_wdata[31]),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .stat_q     (stat_rdata),
    .irq        (irq)
);

// File: tb/sim_spi_autopoll.sv
module sim_spi_autopoll;

    localparam int GAP = 4;

    typedef struct packed {
        logic [2:0]  csel;
        logic [31:0] word;
        logic [7:0]  succ;
        logic [7:0]  good;
        logic [7:0]  bad;
        logic [15:0] ntries;
        logic [2:0]  stat;
    } vec_t;

    // word: run 31, pol 30, bsel 26:24, tmo 19:16, cmd 7:0
    localparam vec_t VECS [0:6] = '{
        '{3'd0, 32'h8000_0005, 8'd3,   8'h02, 8'h03, 16'd4,   3'b010},
        '{3'd0, 32'hC700_0070, 8'd0,   8'h80, 8'h7F, 16'd1,   3'b010},
        '{3'd0, 32'hC300_0035, 8'd255, 8'h08, 8'hF7, 16'd31,  3'b100},
        '{3'd1, 32'h8501_009F, 8'd255, 8'hDF, 8'h20, 16'd124, 3'b100},
        '{3'd2, 32'hC600_000A, 8'd100, 8'h40, 8'hBF, 16'd101, 3'b010},
        '{3'd0, 32'hC201_005C, 8'd61,  8'h04, 8'hFB, 16'd62,  3'b010},
        '{3'd0, 32'h8402_0011, 8'd255, 8'hEF, 8'h10, 16'd124, 3'b100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  clk_sel = '0;
    logic        poll_wr = 1'b0;
    logic [31:0] poll_wdata = '0;
    logic [31:0] poll_rdata;
    logic        mask_wr = 1'b0;
    logic [2:0]  mask_wdata = '0;
    logic        stat_wr = 1'b0;
    logic [2:0]  stat_wdata = '0;
    logic [2:0]  stat_rdata;
    logic        xfer_done = 1'b0;
    logic        irq;
    logic        cs_n;
    logic        xb_req;
    logic [7:0]  xb_tx;
    logic        xb_ack = 1'b0;
    logic [7:0]  xb_rx = '0;

    always #4 clk = !clk;

    spi_autopoll #(.GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst(rst), .clk_sel(clk_sel),
        .poll_wr(poll_wr), .poll_wdata(poll_wdata), .poll_rdata(poll_rdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
        .xfer_done(xfer_done), .irq(irq),
        .cs_n(cs_n), .xb_req(xb_req), .xb_tx(xb_tx), .xb_ack(xb_ack), .xb_rx(xb_rx)
    );

    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;

    // device model state
    int         tries_seen = 0;
    int         byte_idx = 0;
    int         bad_cmd = 0;
    int         bad_len = 0;
    int         irq_cnt = 0;
    int         gap_run = 0;
    int         min_gap = 1000000;
    int         max_gap = 0;
    int         succ_after = 0;
    logic [7:0] exp_cmd = '0;
    logic [7:0] good_b = '0;
    logic [7:0] bad_b = '0;
    logic       prev_cs = 1'b1;
    logic       last_good = 1'b0;
    logic       collide = 1'b0;
    logic       col_arm = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                if (tries_seen > 0) begin
                    if (gap_run < min_gap) min_gap = gap_run;
                    if (gap_run > max_gap) max_gap = gap_run;
                end
                tries_seen++;
                byte_idx = 0;
                gap_run  = 0;
            end
            if (cs_n) gap_run++;
            if (!prev_cs && cs_n && byte_idx != 2) bad_len++;
            if (!cs_n && xb_req) begin
                if (byte_idx == 0) begin
                    if (xb_tx !== exp_cmd) bad_cmd++;
                    xb_rx = (tries_seen > succ_after) ? bad_b : good_b;
                end else begin
                    if (xb_tx !== 8'h00) bad_cmd++;
                    last_good = (tries_seen > succ_after);
                    xb_rx = last_good ? good_b : bad_b;
                end
                xb_ack = 1'b1;
                byte_idx++;
            end else begin
                xb_ack = 1'b0;
            end
            if (collide && !prev_cs && cs_n && last_good) begin
                xfer_done  = 1'b1;
                stat_wr    = 1'b1;
                stat_wdata = 3'b111;
                col_arm    = 1'b1;
            end else if (col_arm) begin
                xfer_done  = 1'b0;
                stat_wr    = 1'b0;
                stat_wdata = 3'b000;
                col_arm    = 1'b0;
            end
            if (irq) irq_cnt++;
            prev_cs = cs_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_poll(input logic [31:0] w);
        @(negedge clk);
        poll_wr = 1'b1;
        poll_wdata = w;
        @(negedge clk);
        poll_wr = 1'b0;
    endtask

    task automatic write_stat(input logic [2:0] b);
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = b;
        @(negedge clk);
        stat_wr = 1'b0;
        stat_wdata = 3'b000;
    endtask

    task automatic write_mask(input logic [2:0] b);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_wdata = b;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic load_vec(input vec_t v);
        clk_sel    = v.csel;
        good_b     = v.good;
        bad_b      = v.bad;
        succ_after = int'(v.succ);
        exp_cmd    = v.word[7:0];
        tries_seen = 0;
        bad_cmd    = 0;
        bad_len    = 0;
        irq_cnt    = 0;
        min_gap    = 1000000;
        max_gap    = 0;
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (poll_rdata[31] && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 20000) chk("R4 busy never cleared", 32'd1, 32'd0);
        settle();
    endtask

    task automatic run_vec(input vec_t v, input int exp_irq, input bit keep);
        logic [2:0] base;
        base = stat_rdata;
        load_vec(v);
        write_poll(v.word);
        chk("R4 busy readback", poll_rdata, v.word);
        wait_idle();
        chk("R3 try count", tries_seen, 32'(v.ntries));
        chk("R2 R6 outcome status", 32'(stat_rdata), 32'(v.stat | base));
        chk("R9 irq pulses", irq_cnt, exp_irq);
        chk("R1 command bytes", bad_cmd, 0);
        chk("R1 bytes per try", bad_len, 0);
        if (v.ntries > 1) begin
            chk("R5 min gap", min_gap, GAP + 1);
            chk("R5 max gap", max_gap, GAP + 1);
        end
        chk("R4 idle readback", poll_rdata, {1'b0, v.word[30:0]});
        if (!keep) begin
            write_stat(3'b111);
            chk("R7 clear all", 32'(stat_rdata), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 status", 32'(stat_rdata), 0);
        chk("R11 poll word", poll_rdata, 0);
        chk("R11 cs_n", 32'(cs_n), 1);
        chk("R11 xb_req", 32'(xb_req), 0);
        chk("R11 irq", 32'(irq), 0);

        for (int i = 0; i < 7; i++) begin
            run_vec(VECS[i], 1, 1'b0);
        end

        // R8 masked success: status recorded, no pulse
        write_mask(3'b010);
        run_vec(VECS[1], 0, 1'b0);
        write_mask(3'b000);

        // R6 R9 transfer-finished event
        irq_cnt = 0;
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        settle();
        chk("R6 xfer bit", 32'(stat_rdata), 32'b001);
        chk("R9 xfer irq", irq_cnt, 1);

        // R7 partial clears on top of a kept success
        run_vec(VECS[0], 1, 1'b1);
        write_stat(3'b000);
        chk("R7 write zero no effect", 32'(stat_rdata), 32'b011);
        write_stat(3'b001);
        chk("R7 clear bit0 only", 32'(stat_rdata), 32'b010);
        write_stat(3'b010);
        chk("R7 clear bit1", 32'(stat_rdata), 32'b000);

        // R10 abort mid-run
        load_vec(VECS[2]);
        write_poll(VECS[2].word);
        repeat (40) @(negedge clk);
        write_poll({1'b0, VECS[2].word[30:0]});
        chk("R10 busy after abort", 32'(poll_rdata[31]), 0);
        chk("R10 cs_n after abort", 32'(cs_n), 1);
        begin
            int snap;
            snap = tries_seen;
            repeat (40) @(negedge clk);
            chk("R10 no further tries", tries_seen, snap);
        end
        chk("R10 no status", 32'(stat_rdata), 0);
        chk("R10 no irq", irq_cnt, 0);

        // R7 R9 completion, transfer event and clear in one cycle
        load_vec(VECS[1]);
        collide = 1'b1;
        write_poll(VECS[1].word);
        wait_idle();
        collide = 1'b0;
        chk("R7 set beats clear", 32'(stat_rdata), 32'b011);
        chk("R9 single pulse for two rises", irq_cnt, 1);
        write_stat(3'b111);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule